// File: doc/BRIEF.md
# Dual-Tap Programmable Delay Line

This block delays a single-bit input stream and presents two delayed copies of it, A and B. Each copy has its own delay, measured in clock cycles and picked by a 4-bit code. The delay equals a fixed minimum plus the code times a step size. Both copies read from one shared shift history of the input. Because of this, every edge of a pulse moves by the same amount, and the pulse width survives unchanged.

Each code input sits behind an enable. While the enable is high, the code passes straight through. When the enable goes low, the code last sampled is held, so both codes can be loaded one after the other from a single 8-bit bus.

Whenever the effective delay of a copy changes, its valid flag drops for a settling interval. The interval is shorter for a direct code change than for a change made through the enable. During that interval the copy already follows the new delay.

Top module: `dual_tap_delay`

## Requirements
- R1: While `rst` is high, `out_a` and `out_b` are 0 and both valid flags are 1. Reset clears the input history, so input values present during reset never reach an output.
- R2: With effective code c, the delay is D = MIN_DELAY + c*STEP cycles, with defaults MIN_DELAY=9 and STEP=3. The output value after clock edge k equals `din` as sampled at edge k-D.
- R3: The code is unsigned binary with bit 0 as the LSB. Code 0 gives MIN_DELAY and code 15 gives MIN_DELAY+15*STEP (54 by default).
- R4: A high pulse of W cycles on `din` appears on each output as a high pulse of exactly W cycles.
- R5: While an enable is 1, its code input is transparent, and a new code sets the delay from the next clock edge.
- R6: While an enable is 0, the code sampled at the last edge where the enable was 1 stays in force. Code input changes are then ignored: the delay does not move and the valid flag stays 1.
- R7: A change of effective code while the enable is steady drives that output's valid flag low for exactly 10 cycles.
- R8: A change of effective code that coincides with a change of that output's enable drives the valid flag low for exactly 15 cycles.
- R9: Programming one output leaves the other output's delay and valid flag untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one delay unit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input waveform |
| en_a | input | 1 | Code enable for output A (1 = transparent, 0 = hold) |
| code_a | input | 4 | Delay code for output A |
| en_b | input | 1 | Code enable for output B (1 = transparent, 0 = hold) |
| code_b | input | 4 | Delay code for output B |
| out_a | output | 1 | Delayed copy A |
| valid_a | output | 1 | Output A settled at its current delay |
| out_b | output | 1 | Delayed copy B |
| valid_b | output | 1 | Output B settled at its current delay |

## Verification
Single isolated pulses are swept through all sixteen codes. A is given ascending codes while B is given descending ones, so each run measures both the arrival cycle and the width. These runs separate an error in the code-to-delay arithmetic from a broken edge or width. A run of random input bits, with occasional direct code changes, is compared against a reference delay in every cycle in which valid is high. This run exposes tap-selection errors that a single isolated pulse can hide. Directed sequences drive a direct change, an enable-coupled change and scrambled codes while the enable is held low. They tell the 10-cycle settle from the 15-cycle settle, and they show that a held code really ignores its inputs.

// File: rtl/dtd_pkg.sv
package dtd_pkg;

    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    // Kind of change seen on the effective code at a clock edge
    typedef enum logic [1:0] {
        CHG_NONE   = 2'd0,
        CHG_DIRECT = 2'd1,
        CHG_ENABLE = 2'd2
    } chg_e;

    typedef struct packed {
        code_t code;
        chg_e  chg;
    } tap_cfg_t;

    function automatic int unsigned delay_of(code_t c, int unsigned min_d, int unsigned step);
        return min_d + 32'(c) * step;
    endfunction

endpackage

// File: rtl/dtd_history.sv
module dtd_history #(
    parameter int DEPTH = 54
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] hist
);

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[DEPTH-2:0], din};
    end

endmodule

// File: rtl/dtd_code_latch.sv
module dtd_code_latch
    import dtd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  code_t    code_in,
    output tap_cfg_t cfg
);

    code_t held_q;
    code_t prev_q;
    code_t eff;
    logic  en_prev_q;

    // Transparent while enabled, otherwise the last captured code
    always_comb eff = en ? code_in : held_q;

    always_ff @(posedge clk) begin
        if (rst)     held_q <= '0;
        else if (en) held_q <= code_in;
    end

    // Edge-to-edge history for change detection; no reset needed
    always_ff @(posedge clk) begin
        prev_q    <= eff;
        en_prev_q <= en;
    end

    always_comb begin
        cfg.code = eff;
        if (eff == prev_q)         cfg.chg = CHG_NONE;
        else if (en != en_prev_q)  cfg.chg = CHG_ENABLE;
        else                       cfg.chg = CHG_DIRECT;
    end

    // R6: with the enable low on consecutive edges the effective code cannot move
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(en) && !$past(rst)) |-> (eff == $past(eff)));

endmodule

// File: rtl/dtd_tap.sv
module dtd_tap
    import dtd_pkg::*;
#(
    parameter int DEPTH         = 54,
    parameter int MIN_DELAY     = 9,
    parameter int STEP          = 3,
    parameter int SETTLE_DIRECT = 10,
    parameter int SETTLE_ENABLE = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] hist,
    input  tap_cfg_t         cfg,
    output logic             dout,
    output logic             valid
);

    localparam int SETTLE_MAX = (SETTLE_ENABLE > SETTLE_DIRECT) ? SETTLE_ENABLE : SETTLE_DIRECT;
    localparam int CW         = $clog2(SETTLE_MAX + 1);
    localparam int IDX_W      = $clog2(DEPTH);

    logic [IDX_W-1:0] idx;
    logic [CW-1:0]    cnt_q;

    // Registered output adds the final cycle, so tap D-1 yields D cycles
    always_comb idx = IDX_W'(delay_of(cfg.code, MIN_DELAY, STEP) - 1);

    always_ff @(posedge clk) begin
        if (rst) dout <= 1'b0;
        else     dout <= hist[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (cfg.chg)
                CHG_ENABLE: cnt_q <= CW'(SETTLE_ENABLE);
                CHG_DIRECT: cnt_q <= CW'(SETTLE_DIRECT);
                default:    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            endcase
        end
    end

    always_comb valid = (cnt_q == '0);

    // R2: the selected tap always lies inside the shared history
    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        32'(idx) < DEPTH);

    // R7: any change of effective code opens a not-valid window
    p_settle_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.chg != CHG_NONE) |=> !valid);

    // R8: with no change pending a settled tap stays settled
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && cfg.chg == CHG_NONE) |=> valid);

endmodule

// File: rtl/dual_tap_delay.sv
module dual_tap_delay
    import dtd_pkg::*;
#(
    parameter int MIN_DELAY     = 9,
    parameter int STEP          = 3,
    parameter int SETTLE_DIRECT = 10,
    parameter int SETTLE_ENABLE = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic       en_a,
    input  logic [3:0] code_a,
    input  logic       en_b,
    input  logic [3:0] code_b,
    output logic       out_a,
    output logic       valid_a,
    output logic       out_b,
    output logic       valid_b
);

    localparam int DEPTH  = MIN_DELAY + (NUM_CODES - 1) * STEP;
    localparam int N_TAPS = 2;

    logic [DEPTH-1:0] hist;
    logic             en_v    [N_TAPS];
    code_t            code_v  [N_TAPS];
    logic             out_v   [N_TAPS];
    logic             valid_v [N_TAPS];

    always_comb begin
        en_v[0]   = en_a;
        code_v[0] = code_a;
        en_v[1]   = en_b;
        code_v[1] = code_b;
    end

    assign out_a   = out_v[0];
    assign valid_a = valid_v[0];
    assign out_b   = out_v[1];
    assign valid_b = valid_v[1];

    dtd_history #(.DEPTH(DEPTH)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .hist (hist)
    );

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        tap_cfg_t cfg;

        dtd_code_latch u_latch (
            .clk     (clk),
            .rst     (rst),
            .en      (en_v[g]),
            .code_in (code_v[g]),
            .cfg     (cfg)
        );

        dtd_tap #(
            .DEPTH         (DEPTH),
            .MIN_DELAY     (MIN_DELAY),
            .STEP          (STEP),
            .SETTLE_DIRECT (SETTLE_DIRECT),
            .SETTLE_ENABLE (SETTLE_ENABLE)
        ) u_tap (
            .clk   (clk),
            .rst   (rst),
            .hist  (hist),
            .cfg   (cfg),
            .dout  (out_v[g]),
            .valid (valid_v[g])
        );
    end

endmodule

// File: tb/dual_tap_delay_tb.sv
module dual_tap_delay_tb;

    localparam int CLK       = 10;
    localparam int MIN_DELAY = 9;
    localparam int STEP      = 3;
    localparam int MAXD      = MIN_DELAY + 15 * STEP;

    logic       clk = 1'b0;
    logic       rst;
    logic       din;
    logic       en_a, en_b;
    logic [3:0] code_a, code_b;
    logic       out_a, valid_a, out_b, valid_b;

    logic [MAXD:0] bh;
    logic [3:0]    ca_exp, cb_exp;
    logic          mon_on = 1'b0;
    int            checks = 0;
    int            errors = 0;

    always #(CLK/2) clk = ~clk;

    dual_tap_delay #(.MIN_DELAY(MIN_DELAY), .STEP(STEP)) u_dut (
        .clk(clk), .rst(rst), .din(din),
        .en_a(en_a), .code_a(code_a), .en_b(en_b), .code_b(code_b),
        .out_a(out_a), .valid_a(valid_a), .out_b(out_b), .valid_b(valid_b)
    );

    function automatic int dly(logic [3:0] c);
        return MIN_DELAY + int'(c) * STEP;
    endfunction

    // Reference: bh[d] after edge k holds din sampled at edge k-d
    always @(posedge clk) begin
        if (rst) bh <= '0;
        else     bh <= {bh[MAXD-1:0], din};
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic obs();
        @(posedge clk);
        #(CLK/4);
    endtask

    // R2 running comparison whenever an output reports valid
    always begin
        obs();
        if (mon_on && !rst) begin
            if (valid_a) chk(out_a == bh[dly(ca_exp)], "R2 out_a", int'(out_a), int'(bh[dly(ca_exp)]));
            if (valid_b) chk(out_b == bh[dly(cb_exp)], "R2 out_b", int'(out_b), int'(bh[dly(cb_exp)]));
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Settle window on one channel, other channel must stay valid (R9)
    task automatic settle_win(bit ch_b, int len, string req);
        for (int i = 0; i < len; i++) begin
            obs();
            chk((ch_b ? valid_b : valid_a) == 1'b0, req, int'(ch_b ? valid_b : valid_a), 0);
            chk((ch_b ? valid_a : valid_b) == 1'b1, "R9 other valid", int'(ch_b ? valid_a : valid_b), 1);
        end
        obs();
        chk((ch_b ? valid_b : valid_a) == 1'b1, req, int'(ch_b ? valid_b : valid_a), 1);
    endtask

    task automatic pulse_run(int w, string tag);
        int fa = -1, fb = -1, wa = 0, wb = 0;
        for (int t = 0; t < MAXD + w + 10; t++) begin
            @(negedge clk);
            din = (t < w);
            obs();
            if (out_a && fa < 0) fa = t;
            if (out_b && fb < 0) fb = t;
            if (out_a) wa++;
            if (out_b) wb++;
        end
        chk(fa == dly(ca_exp), {"R3 rise A ", tag}, fa, dly(ca_exp));
        chk(fb == dly(cb_exp), {"R3 rise B ", tag}, fb, dly(cb_exp));
        chk(wa == w, {"R4 width A ", tag}, wa, w);
        chk(wb == w, {"R4 width B ", tag}, wb, w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240));
        rst = 1'b1; din = 1'b1;
        en_a = 1'b1; en_b = 1'b1;
        code_a = 4'd0; code_b = 4'd0;
        ca_exp = 4'd0; cb_exp = 4'd0;
        repeat (3) obs();
        // R1: reset state
        chk(out_a == 1'b0 && out_b == 1'b0, "R1 outputs in reset", int'({out_a, out_b}), 0);
        chk(valid_a && valid_b, "R1 valid in reset", int'({valid_a, valid_b}), 3);

        @(negedge clk);
        rst = 1'b0; din = 1'b1; mon_on = 1'b1;
        repeat (MIN_DELAY) obs();
        chk(out_a == 1'b0, "R1 history cleared", int'(out_a), 0);
        obs();
        chk(out_a == 1'b1, "R2 first arrival at MIN_DELAY", int'(out_a), 1);
        @(negedge clk); din = 1'b0;
        repeat (MAXD + 4) @(negedge clk);

        // R3/R4/R5: sweep all codes, A ascending and B descending, transparent
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            code_a = 4'(c); code_b = 4'(15 - c);
            ca_exp = 4'(c); cb_exp = 4'(15 - c);
            repeat (MAXD + 4) @(negedge clk);
            pulse_run(3 + c, "sweep R5");
        end

        // R7: direct change on A, B untouched
        @(negedge clk); code_a = 4'd2; ca_exp = 4'd2;
        settle_win(1'b0, 10, "R7 direct A");
        @(negedge clk); code_b = 4'd7; cb_exp = 4'd7;
        settle_win(1'b1, 10, "R7 direct B");

        // R6: hold A with enable low, scramble its code input
        @(negedge clk); code_a = 4'd5; ca_exp = 4'd5;
        repeat (20) @(negedge clk);
        en_a = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            code_a = 4'($urandom_range(0, 15));
            din = 1'($urandom_range(0, 1));
            obs();
            chk(valid_a == 1'b1, "R6 held code ignores input", int'(valid_a), 1);
        end
        @(negedge clk); din = 1'b0;
        repeat (MAXD + 4) @(negedge clk);
        pulse_run(6, "R6 held delay");

        // R8: enable-coupled change on A
        @(negedge clk); en_a = 1'b1; code_a = 4'd11; ca_exp = 4'd11;
        settle_win(1'b0, 15, "R8 enable A");
        repeat (12) @(negedge clk);
        en_a = 1'b0;
        // R8 on B via shared bus style: load B while A is held
        @(negedge clk); en_b = 1'b0;
        @(negedge clk); en_b = 1'b1; code_b = 4'd14; cb_exp = 4'd14;
        settle_win(1'b1, 15, "R8 enable B");
        repeat (12) @(negedge clk);
        en_b = 1'b0; code_b = 4'd3;
        repeat (MAXD + 4) @(negedge clk);
        pulse_run(9, "R8 latched");

        // Random phase: run-length input with occasional direct changes
        en_a = 1'b1; en_b = 1'b1; code_a = ca_exp; code_b = cb_exp;
        begin
            int run = 0;
            for (int i = 0; i < 4000; i++) begin
                @(negedge clk);
                if (run == 0) begin
                    din = ~din;
                    run = $urandom_range(1, 20);
                end
                run--;
                if ($urandom_range(0, 199) == 0) begin
                    code_a = 4'($urandom_range(0, 15)); ca_exp = code_a;
                end
                if ($urandom_range(0, 199) == 0) begin
                    code_b = 4'($urandom_range(0, 15)); cb_exp = code_b;
                end
            end
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule